// File: doc/BRIEF.md
# Serial Ready/Data Output Port Model

This block is a synthesizable device-side stand-in for the digital output side of a serial sigma-delta converter. It is meant as a test partner or emulator. An internal timer marks when each conversion completes. At that moment the block captures a parallel result, and an error flag, from its inputs. It then presents them to a host over a single output pin that doubles as the ready flag, and it shifts them out on the host's serial clock. The modulator and the digital filter are not modelled: the host environment supplies the numbers.

The pin idles high. It drops low when a fresh result is waiting. On each falling serial-clock edge it moves to the next bit of a 32-bit word. After a complete read it returns high, so each result can be read only once. The block also pulls the pin high a few clocks before a pending result would be overwritten.

Two other events restart the settling wait. A change on either the response-select input or the gain-select input restarts it and forces the pin high. A power-down input does the same, and while it is low the pin is released (tri-stated) and all state is cleared.

Top module: `sdrdy_port`

## Requirements
- R1: While `pd_n` is low, `sdo_en` is 0 and all state is cleared. On the first clock edge after `pd_n` and `rst_n` are both high (the restart edge), `sdo_en` becomes 1 and `sdo` is 1. A power-on reset through `rst_n` acts the same way.
- R2: After a restart edge, `sdo` stays 1 for S−1 further clock edges and goes 0 on edge S after the restart edge. S is SETTLE_SLOW when `filt_slow`=1 and SETTLE_FAST when `filt_slow`=0.
- R3: While ready, each falling `sclk` edge seen at a clock edge advances the word by one bit, and `sdo` shows that bit, MSB first. The 32-bit word is built as follows:
  - bits 31..12 hold the result;
  - bits 11..8 are 0;
  - bit 7 is the ready bit (0);
  - bit 6 is 1 for the slow response;
  - bit 5 is the error flag;
  - bits 4..3 are 00;
  - bit 2 is 1 for unity gain;
  - bits 1..0 are 01.
- R4: The clock edge that sees the 32nd rising `sclk` edge of a read ends the read, and `sdo` returns to 1. Further `sclk` pulses read only ones until the next conversion.
- R5: Conversions follow one another every P clocks, where P is PERIOD_SLOW or PERIOD_FAST according to the response in effect. Each conversion loads the result present at that edge, and `sdo` goes 0.
- R6: If a result is still unread, `sdo` goes to 1 LEAD clocks before the next conversion edge. It drops back to 0 at that edge, now carrying the new result.
- R7: A change on `filt_slow` or `gain_unity` is a restart edge. `sdo` is 1 from that edge on and stays 1 for the new setting's settle time (as in R2). Serial clocks during that window read only ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| pd_n | input | 1 | Power-down/reset, active low |
| filt_slow | input | 1 | 1 selects the slow (10 Hz) response, 0 the faster one |
| gain_unity | input | 1 | 1 selects unity gain, 0 the high gain |
| conv_data | input | RES_W | Conversion result captured at each conversion edge |
| conv_err | input | 1 | Out-of-range flag captured with the result |
| sclk | input | 1 | Host serial clock, sampled by clk, idle high |
| sdo | output | 1 | Combined ready/data pin value |
| sdo_en | output | 1 | Pin drive enable; 0 means tri-stated |

## Verification
The bench builds the block with settle times of 36 and 60 clocks and conversion periods of 180 and 220 clocks, using a warning lead of 6 clocks. With these values, the bench can hit every timing boundary at its exact clock edge. It can check both filter settings, the pre-update withdrawal of an unread result and a settings change inside one short run. A read takes 64 clocks, which fits between conversions with margin. It is longer than the fast settle window, so the bench can probe that window for all-ones reads.

// File: rtl/sdrdy_pkg.sv
package sdrdy_pkg;
  typedef struct packed {
    logic       rdy_n;
    logic       slow;
    logic       err;
    logic [1:0] id;
    logic       unity;
    logic [1:0] pat;
  } stat_t;

  function automatic stat_t make_stat(logic slow, logic err, logic unity);
    stat_t s;
    s.rdy_n = 1'b0;
    s.slow  = slow;
    s.err   = err;
    s.id    = 2'b00;
    s.unity = unity;
    s.pat   = 2'b01;
    return s;
  endfunction
endpackage

// File: rtl/sdrdy_timer.sv
module sdrdy_timer #(
  parameter int S_SLOW = 4000,
  parameter int S_FAST = 2400,
  parameter int P_SLOW = 1000,
  parameter int P_FAST = 600,
  parameter int LEAD   = 16,
  parameter int CNT_W  = 12
) (
  input  logic clk,
  input  logic arst_n,
  input  logic restart,
  input  logic slow_new,
  input  logic slow_cur,
  output logic conv_evt,
  output logic warn_evt
);
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] load_val(logic slow, int a, int b);
    return slow ? CNT_W'(a - 1) : CNT_W'(b - 1);
  endfunction

  assign conv_evt = !restart && (cnt == '0);
  assign warn_evt = !restart && (cnt == CNT_W'(LEAD));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          cnt <= '0;
    else if (restart)     cnt <= load_val(slow_new, S_SLOW, S_FAST);
    else if (cnt == '0)   cnt <= load_val(slow_cur, P_SLOW, P_FAST);
    else                  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sdrdy_shift.sv
module sdrdy_shift #(
  parameter int WORD_W = 32,
  parameter int BIT_W  = 6
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             clr,
  input  logic             rdy,
  input  logic             sclk,
  output logic [BIT_W-1:0] bitcnt,
  output logic             read_done
);
  logic sclk_q;
  logic fall, rise;

  assign fall      = sclk_q && !sclk;
  assign rise      = !sclk_q && sclk;
  assign read_done = rdy && rise && !clr && (bitcnt == BIT_W'(WORD_W));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sclk_q <= 1'b1;
      bitcnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (clr || read_done)
        bitcnt <= '0;
      else if (rdy && fall && bitcnt < BIT_W'(WORD_W))
        bitcnt <= bitcnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdrdy_port.sv
module sdrdy_port #(
  parameter int RES_W       = 20,
  parameter int SETTLE_SLOW = 4000,
  parameter int SETTLE_FAST = 2400,
  parameter int PERIOD_SLOW = 1000,
  parameter int PERIOD_FAST = 600,
  parameter int LEAD        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             filt_slow,
  input  logic             gain_unity,
  input  logic [RES_W-1:0] conv_data,
  input  logic             conv_err,
  input  logic             sclk,
  output logic             sdo,
  output logic             sdo_en
);
  import sdrdy_pkg::*;

  localparam int PAD_W  = 4;
  localparam int WORD_W = RES_W + PAD_W + $bits(stat_t);
  localparam int MAX_S  = (SETTLE_SLOW > SETTLE_FAST) ? SETTLE_SLOW : SETTLE_FAST;
  localparam int MAX_P  = (PERIOD_SLOW > PERIOD_FAST) ? PERIOD_SLOW : PERIOD_FAST;
  localparam int MAX_C  = (MAX_S > MAX_P) ? MAX_S : MAX_P;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int BIT_W  = $clog2(WORD_W + 1);

  function automatic logic [WORD_W-1:0] pack_word(logic [RES_W-1:0] res, stat_t st);
    return {res, {PAD_W{1'b0}}, st};
  endfunction

  function automatic logic word_bit(logic [WORD_W-1:0] w, logic [BIT_W-1:0] n);
    if (n == '0) return 1'b0;
    return w[WORD_W - int'(n)];
  endfunction

  logic              arst_n;
  logic              armed, filt_q, gain_q, rdy, en_q;
  logic [WORD_W-1:0] word_q;
  logic              chg, restart, conv_evt, warn_evt, read_done, shift_clr;
  logic [BIT_W-1:0]  bitcnt;

  assign arst_n    = rst_n && pd_n;
  assign chg       = armed && ((filt_slow != filt_q) || (gain_unity != gain_q));
  assign restart   = !armed || chg;
  assign shift_clr = restart || conv_evt || warn_evt;

  sdrdy_timer #(
    .S_SLOW(SETTLE_SLOW), .S_FAST(SETTLE_FAST),
    .P_SLOW(PERIOD_SLOW), .P_FAST(PERIOD_FAST),
    .LEAD(LEAD), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .arst_n(arst_n), .restart(restart),
    .slow_new(filt_slow), .slow_cur(filt_q),
    .conv_evt(conv_evt), .warn_evt(warn_evt)
  );

  sdrdy_shift #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_shift (
    .clk(clk), .arst_n(arst_n), .clr(shift_clr), .rdy(rdy),
    .sclk(sclk), .bitcnt(bitcnt), .read_done(read_done)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      armed  <= 1'b0;
      filt_q <= 1'b0;
      gain_q <= 1'b0;
      rdy    <= 1'b0;
      en_q   <= 1'b0;
      word_q <= '0;
    end else begin
      en_q <= 1'b1;
      if (restart) begin
        armed  <= 1'b1;
        filt_q <= filt_slow;
        gain_q <= gain_unity;
        rdy    <= 1'b0;
      end else if (conv_evt) begin
        word_q <= pack_word(conv_data, make_stat(filt_q, conv_err, gain_q));
        rdy    <= 1'b1;
      end else if (warn_evt || read_done) begin
        rdy    <= 1'b0;
      end
    end
  end

  assign sdo    = rdy ? word_bit(word_q, bitcnt) : 1'b1;
  assign sdo_en = en_q;
endmodule

// File: rtl/sdrdy_port_chk.sv
module sdrdy_port_chk (
  input logic clk,
  input logic rst_n,
  input logic arst_n,
  input logic pd_n,
  input logic rdy,
  input logic conv_evt,
  input logic warn_evt,
  input logic read_done,
  input logic restart,
  input logic chg,
  input logic sdo,
  input logic sdo_en
);
  p_tristate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> !sdo_en);

  p_restart_clears_r2: assert property (@(posedge clk) disable iff (!arst_n)
    restart |=> !rdy);

  p_done_high_r4: assert property (@(posedge clk) disable iff (!arst_n)
    read_done |=> sdo);

  p_evt_low_r5: assert property (@(posedge clk) disable iff (!arst_n)
    conv_evt |=> (rdy && !sdo));

  p_warn_high_r6: assert property (@(posedge clk) disable iff (!arst_n)
    warn_evt |=> sdo);

  p_warn_apart_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !(warn_evt && conv_evt));

  p_change_high_r7: assert property (@(posedge clk) disable iff (!arst_n)
    chg |=> (sdo && !rdy));
endmodule

bind sdrdy_port sdrdy_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arst_n(arst_n), .pd_n(pd_n), .rdy(rdy),
  .conv_evt(conv_evt), .warn_evt(warn_evt), .read_done(read_done),
  .restart(restart), .chg(chg), .sdo(sdo), .sdo_en(sdo_en)
);

// File: tb/sdrdy_port_test.sv
module sdrdy_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 20;
  localparam int SS = 60, SF = 36, PS = 220, PF = 180, LD = 6;

  logic clk = 1'b0, rst_n, pd_n, filt_slow, gain_unity, conv_err, sclk;
  logic [RW-1:0] conv_data;
  logic sdo, sdo_en;
  int cyc = 0, tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdrdy_port #(.RES_W(RW), .SETTLE_SLOW(SS), .SETTLE_FAST(SF),
    .PERIOD_SLOW(PS), .PERIOD_FAST(PF), .LEAD(LD)) uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .filt_slow(filt_slow),
    .gain_unity(gain_unity), .conv_data(conv_data), .conv_err(conv_err),
    .sclk(sclk), .sdo(sdo), .sdo_en(sdo_en));

  // err flag in bit 20, result in bits 19..0
  localparam logic [20:0] VEC [6] = '{
    21'h0_00000, 21'h0_FFFFF, 21'h0_80000, 21'h1_7FFFF, 21'h1_A5A5A, 21'h0_00001};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(logic [RW-1:0] d, logic e, logic f, logic g);
    return (32'(d) * 32'd4096) + (f ? 32'd64 : 0) + (e ? 32'd32 : 0) + (g ? 32'd4 : 0) + 32'd1;
  endfunction

  task automatic at_cycle(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic read_word(output logic [31:0] w);
    w = '0;
    for (int i = 0; i < 32; i++) begin
      sclk = 1'b0; @(negedge clk);
      w = {w[30:0], sdo};
      sclk = 1'b1; @(negedge clk);
    end
  endtask

  task automatic wait_low();
    int guard = 0;
    while (sdo !== 1'b0 && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int e0, ev, r0, r1;
    logic ones;
    rst_n = 0; pd_n = 0; sclk = 1; filt_slow = 0; gain_unity = 0;
    conv_err = 0; conv_data = 20'h12345;
    repeat (3) @(negedge clk);
    chk("R1 reset tristate", 32'(sdo_en), 0);
    rst_n = 1; repeat (2) @(negedge clk);
    chk("R1 pd low tristate", 32'(sdo_en), 0);
    pd_n = 1; e0 = cyc + 1;
    at_cycle(e0);
    chk("R1 enabled after release", 32'(sdo_en), 1);
    chk("R1 high after release", 32'(sdo), 1);
    at_cycle(e0 + SF - 1); chk("R2 fast settle still high", 32'(sdo), 1);
    at_cycle(e0 + SF);     chk("R2 fast settle ready", 32'(sdo), 0);
    ev = e0 + SF;
    read_word(w);
    chk("R3 word fast/128", w, expect_word(20'h12345, 0, 0, 0));
    chk("R4 high after read", 32'(sdo), 1);
    ones = 1;
    for (int k = 0; k < 4; k++) begin
      sclk = 0; @(negedge clk); ones &= sdo;
      sclk = 1; @(negedge clk); ones &= sdo;
    end
    chk("R4 reread gives ones", 32'(ones), 1);
    conv_data = 20'hBBBBB;
    at_cycle(ev + PF - 1); chk("R5 before next conversion", 32'(sdo), 1);
    at_cycle(ev + PF);     chk("R5 next conversion ready", 32'(sdo), 0);
    conv_data = 20'hCCCCC;
    at_cycle(ev + 2*PF - LD - 1); chk("R6 still ready before lead", 32'(sdo), 0);
    at_cycle(ev + 2*PF - LD);     chk("R6 withdrawn at lead", 32'(sdo), 1);
    at_cycle(ev + 2*PF);          chk("R6 ready with new result", 32'(sdo), 0);
    read_word(w);
    chk("R6 replaced result", w, expect_word(20'hCCCCC, 0, 0, 0));
    at_cycle(ev + 3*PF); chk("R5 ready again", 32'(sdo), 0);
    gain_unity = 1; conv_data = 20'h0D0D0; r0 = cyc + 1;
    at_cycle(r0); chk("R7 high after gain change", 32'(sdo), 1);
    ones = 1;
    for (int k = 0; k < 8; k++) begin
      sclk = 0; @(negedge clk); ones &= sdo;
      sclk = 1; @(negedge clk); ones &= sdo;
    end
    chk("R7 window reads ones", 32'(ones), 1);
    at_cycle(r0 + SF - 1); chk("R7 settle still high", 32'(sdo), 1);
    at_cycle(r0 + SF);     chk("R7 settled ready", 32'(sdo), 0);
    read_word(w);
    chk("R3 word unity gain", w, expect_word(20'h0D0D0, 0, 0, 1));
    filt_slow = 1; r1 = cyc + 1;
    at_cycle(r1 + SS - 1); chk("R2 slow settle still high", 32'(sdo), 1);
    at_cycle(r1 + SS);     chk("R2 slow settle ready", 32'(sdo), 0);
    read_word(w);
    chk("R3 word slow response", w, expect_word(20'h0D0D0, 0, 1, 1));
    conv_data = 20'hE1E1E;
    at_cycle(r1 + SS + PS - 1); chk("R5 slow period high", 32'(sdo), 1);
    at_cycle(r1 + SS + PS);     chk("R5 slow period ready", 32'(sdo), 0);
    read_word(w);
    chk("R5 slow period result", w, expect_word(20'hE1E1E, 0, 1, 1));
    for (int v = 0; v < 6; v++) begin
      conv_data = VEC[v][19:0]; conv_err = VEC[v][20];
      wait_low();
      read_word(w);
      chk("R3 vector word", w, expect_word(VEC[v][19:0], VEC[v][20], 1, 1));
    end
    wait_low();
    sclk = 0; @(negedge clk); sclk = 1;
    pd_n = 0; #1;
    chk("R1 tristate mid-read", 32'(sdo_en), 0);
    @(negedge clk); pd_n = 1; e0 = cyc + 1;
    at_cycle(e0); chk("R1 high after second release", 32'(sdo), 1);
    at_cycle(e0 + SS); chk("R2 slow settle after power-down", 32'(sdo), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule